// File: doc/BRIEF.md
# Shared PCI Interrupt Line Router

This block takes eight shared PCI interrupt request levels (lines A to H) and one power-management event level (SCI). It drives two sets of interrupt controller inputs at the same time: sixteen legacy PIC request pins and twenty-four I/O APIC inputs.

Eight steering bytes, one per request line, give each line a PIC pin number and a bit that removes the line from the PIC. A PIC pin is the OR of every line still on the PIC that names it. The APIC side needs no steering, because line n always lands on APIC input 16+n. A separate steering code puts SCI onto one of five fixed interrupt numbers. When that number is below 16, SCI joins both the PIC pin and the APIC input of that number. Otherwise it reaches only the APIC input.

A byte-wide configuration write port loads the steering registers. A query port takes a line number and reports where that line currently goes, so that interrupt tables can be built from it. All outputs follow the registers and input levels combinationally.

Top module: `pirq_irq_router`

## Requirements
- R1: After reset every steering byte is 0x80 (line off the PIC, pin field 0), the SCI code is 0 and the held SCI level is 0. All PIC outputs are then low, and each query reports the APIC mode.
- R2: A steering byte holds the PIC pin number in bits 4:0 and the off-PIC bit in bit 7. When bit 7 is 1, the line drives no PIC pin. Bits 6:5 have no effect.
- R3: PIC output p is high exactly when some line with bit 7 clear and pin field equal to p is high, or when SCI is steered to p and the held SCI level is 1.
- R4: A line whose pin field is 16 or more, with bit 7 clear, drives no PIC pin.
- R5: APIC input 16+n follows line n for n = 0..7, whatever the steering bytes say. No two lines share an APIC input.
- R6: SCI steering code (bits 2:0 of the SCI control byte) 0, 1, 2, 3 and 4 select interrupt 9, 10, 11, 20 and 21. Codes 5, 6 and 7 leave SCI on no output.
- R7: The held SCI level is ORed into the APIC input whose number equals the selected interrupt.
- R8: SCI reaches a PIC pin only when the selected interrupt is below 16. For interrupts 20 and 21 no PIC pin carries it.
- R9: A pulse on the SCI update strobe sets the held SCI level to the OR of the 4-bit value. The level holds between pulses, and a pulse that carries the level already held changes nothing.
- R10: The query gives mode 1 (APIC) and number 16+n for a line with bit 7 set. It gives mode 2 (none) and number 0 for a line with bit 7 clear and pin field of 16 or more. Otherwise it gives mode 0 (PIC) and the pin field.
- R11: Configuration address 0..7 writes the steering byte of line A..H, and address 8 writes the SCI control byte. Writes to addresses 9..15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register address |
| cfgWrData | input | 8 | Configuration write byte |
| sciWr | input | 1 | SCI level update strobe |
| sciVal | input | 4 | SCI update value, normalised by OR |
| pirqLevel | input | 8 | Request levels of lines A..H (bit 0 = A) |
| picIrq | output | 16 | PIC request pins 0..15 |
| apicIrq | output | 24 | I/O APIC inputs 0..23 |
| qryPirq | input | 3 | Line number to query |
| qryMode | output | 2 | Query mode: 0 PIC, 1 APIC, 2 none |
| qryIrq | output | 5 | Query interrupt number |

## Verification
Directed patterns come first:
- Two enabled lines are put on the same pin, which separates a true wired-OR from last-writer logic.
- One of those lines is then taken off the PIC, which shows the off bit masks only the PIC side.
- A pin field of 20 checks that out-of-range numbers reach no pin and read back as none.

Every SCI code is then walked with SCI both high and low, so that APIC-only targets can be told apart from dual targets and from reserved codes. Seeded random writes over the whole address space, including the unused addresses, are mixed with random line levels and SCI pulses. This covers overlaps of many lines on few pins that the directed cases miss.

// File: rtl/pirq_rtr_pkg.sv
package pirq_rtr_pkg;

  localparam int NUM_PIRQ  = 8;
  localparam int NUM_PIC   = 16;
  localparam int NUM_APIC  = 24;
  localparam int FIELD_W   = 5;
  localparam int OFF_BIT   = 7;
  localparam int ADDR_W    = 4;
  localparam int SCI_VAL_W = 4;
  localparam int SCI_CODE_W = 3;
  localparam int IRQ_W     = $clog2(NUM_APIC);
  localparam int PIRQ_W    = $clog2(NUM_PIRQ);
  localparam logic [7:0] ROUTE_RESET = 8'h80;
  localparam logic [SCI_CODE_W-1:0] SCI_CODE_RESET = '0;
  localparam logic [ADDR_W-1:0] SCI_CTL_ADDR = ADDR_W'(NUM_PIRQ);

  typedef enum logic [1:0] {
    QRY_PIC = 2'd0,
    QRY_GSI = 2'd1,
    QRY_OFF = 2'd2
  } qryMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_PIRQ-1:0] routeWe;
    logic                sciCtlWe;
    logic                sciLoad;
    logic                sciNext;
  } rtrStrobe_t;

  typedef struct packed {
    logic             valid;
    logic [IRQ_W-1:0] line;
  } sciTarget_t;

  function automatic sciTarget_t sciTargetOf(input logic [SCI_CODE_W-1:0] code);
    sciTarget_t t;
    t.valid = 1'b1;
    case (code)
      3'd0:    t.line = IRQ_W'(9);
      3'd1:    t.line = IRQ_W'(10);
      3'd2:    t.line = IRQ_W'(11);
      3'd3:    t.line = IRQ_W'(20);
      3'd4:    t.line = IRQ_W'(21);
      default: begin
        t.valid = 1'b0;
        t.line  = '0;
      end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/pirq_rtr_ctrl.sv
module pirq_rtr_ctrl
  import pirq_rtr_pkg::*;
(
  input  logic                 cfgWrEn,
  input  logic [ADDR_W-1:0]    cfgAddr,
  input  logic                 sciWr,
  input  logic [SCI_VAL_W-1:0] sciVal,
  input  logic                 sciLvl,
  output rtrStrobe_t           strobe
);

  logic sciNorm;

  assign sciNorm = |sciVal;

  generate
    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_we
      assign strobe.routeWe[n] = cfgWrEn && (cfgAddr == ADDR_W'(n));
    end
  endgenerate

  assign strobe.sciCtlWe = cfgWrEn && (cfgAddr == SCI_CTL_ADDR);
  // only a real change of the normalised level loads the register
  assign strobe.sciLoad  = sciWr && (sciNorm != sciLvl);
  assign strobe.sciNext  = sciNorm;

endmodule

// File: rtl/pirq_rtr_dp.sv
module pirq_rtr_dp
  import pirq_rtr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  rtrStrobe_t            strobe,
  input  logic [7:0]            cfgWrData,
  input  logic [NUM_PIRQ-1:0]   pirqLevel,
  input  logic [PIRQ_W-1:0]     qryPirq,
  output logic [NUM_PIC-1:0]    picIrq,
  output logic [NUM_APIC-1:0]   apicIrq,
  output logic [1:0]            qryMode,
  output logic [IRQ_W-1:0]      qryIrq,
  output logic                  sciLvl,
  output logic [SCI_CODE_W-1:0] sciCode
);

  logic [7:0]          routeReg [NUM_PIRQ];
  logic [NUM_PIRQ-1:0] onPic;
  sciTarget_t          sciTgt;
  logic                unusedBits;

  assign unusedBits = ^cfgWrData;

  generate
    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_route
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   routeReg[n] <= ROUTE_RESET;
        else if (strobe.routeWe[n])  routeReg[n] <= cfgWrData;
      end
      assign onPic[n] = !routeReg[n][OFF_BIT];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sciCode <= SCI_CODE_RESET;
    else if (strobe.sciCtlWe) sciCode <= cfgWrData[SCI_CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sciLvl <= 1'b0;
    else if (strobe.sciLoad) sciLvl <= strobe.sciNext;
  end

  assign sciTgt = sciTargetOf(sciCode);

  // PIC side: wired-OR per pin
  generate
    for (genvar p = 0; p < NUM_PIC; p++) begin : g_pic
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int n = 0; n < NUM_PIRQ; n++) begin
          if (onPic[n] && (routeReg[n][FIELD_W-1:0] == FIELD_W'(p)))
            hit = hit | pirqLevel[n];
        end
        if (sciTgt.valid && (sciTgt.line == IRQ_W'(p)))
          hit = hit | sciLvl;
      end
      assign picIrq[p] = hit;
    end
  endgenerate

  // APIC side: fixed one-to-one mapping above the PIC range
  generate
    for (genvar k = 0; k < NUM_APIC; k++) begin : g_apic
      logic sciHit;
      assign sciHit = sciLvl && sciTgt.valid && (sciTgt.line == IRQ_W'(k));
      if ((k >= NUM_PIC) && (k < NUM_PIC + NUM_PIRQ)) begin : g_pirq
        assign apicIrq[k] = pirqLevel[k-NUM_PIC] | sciHit;
      end else begin : g_sci
        assign apicIrq[k] = sciHit;
      end
    end
  endgenerate

  // route query
  logic [7:0] qSel;
  always_comb begin
    qSel = routeReg[qryPirq];
    if (qSel[OFF_BIT]) begin
      qryMode = QRY_GSI;
      qryIrq  = IRQ_W'(NUM_PIC) + IRQ_W'(qryPirq);
    end else if (qSel[FIELD_W-1:0] >= FIELD_W'(NUM_PIC)) begin
      qryMode = QRY_OFF;
      qryIrq  = '0;
    end else begin
      qryMode = QRY_PIC;
      qryIrq  = IRQ_W'(qSel[FIELD_W-1:0]);
    end
  end

endmodule

// File: rtl/pirq_irq_router.sv
module pirq_irq_router
  import pirq_rtr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [3:0]  cfgAddr,
  input  logic [7:0]  cfgWrData,
  input  logic        sciWr,
  input  logic [3:0]  sciVal,
  input  logic [7:0]  pirqLevel,
  output logic [15:0] picIrq,
  output logic [23:0] apicIrq,
  input  logic [2:0]  qryPirq,
  output logic [1:0]  qryMode,
  output logic [4:0]  qryIrq
);

  rtrStrobe_t            strobe;
  logic                  sciLvl;
  logic [SCI_CODE_W-1:0] sciCode;

  pirq_rtr_ctrl u_ctrl (
    .cfgWrEn (cfgWrEn),
    .cfgAddr (cfgAddr),
    .sciWr   (sciWr),
    .sciVal  (sciVal),
    .sciLvl  (sciLvl),
    .strobe  (strobe)
  );

  pirq_rtr_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgWrData (cfgWrData),
    .pirqLevel (pirqLevel),
    .qryPirq   (qryPirq),
    .picIrq    (picIrq),
    .apicIrq   (apicIrq),
    .qryMode   (qryMode),
    .qryIrq    (qryIrq),
    .sciLvl    (sciLvl),
    .sciCode   (sciCode)
  );

endmodule

// File: rtl/pirq_rtr_chk.sv
module pirq_rtr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sciWr,
  input logic [3:0]  sciVal,
  input logic [7:0]  pirqLevel,
  input logic [15:0] picIrq,
  input logic [23:0] apicIrq,
  input logic [1:0]  qryMode,
  input logic [4:0]  qryIrq,
  input logic        sciLvl,
  input logic [2:0]  sciCode
);

  AST_APIC_FOLLOWS_PIRQ: assert property (@(posedge clk) disable iff (!rstN)
    ((apicIrq[23:16] & pirqLevel) == pirqLevel)); // R5

  AST_SCI_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !sciWr |=> $stable(sciLvl)); // R9

  AST_SCI_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    sciWr |=> (sciLvl == (|$past(sciVal)))); // R9

  AST_PIC_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    (picIrq != 16'h0) |-> ((pirqLevel != 8'h0) || sciLvl)); // R3

  AST_SCI_HIGH_NO_PIC: assert property (@(posedge clk) disable iff (!rstN)
    ((sciCode == 3'd3 || sciCode == 3'd4) && pirqLevel == 8'h0) |-> (picIrq == 16'h0)); // R8

  AST_QRY_OFF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (qryMode == 2'd2) |-> (qryIrq == 5'd0)); // R10

endmodule

bind pirq_irq_router pirq_rtr_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sciWr     (sciWr),
  .sciVal    (sciVal),
  .pirqLevel (pirqLevel),
  .picIrq    (picIrq),
  .apicIrq   (apicIrq),
  .qryMode   (qryMode),
  .qryIrq    (qryIrq),
  .sciLvl    (sciLvl),
  .sciCode   (sciCode)
);

// File: tb/pirq_irq_router_bench.sv
`timescale 1ns/1ps
module pirq_irq_router_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [7:0]  cfgWrData = '0;
  logic        sciWr = 1'b0;
  logic [3:0]  sciVal = '0;
  logic [7:0]  pirqLevel = '0;
  logic [15:0] picIrq;
  logic [23:0] apicIrq;
  logic [2:0]  qryPirq = '0;
  logic [1:0]  qryMode;
  logic [4:0]  qryIrq;

  int checks = 0;
  int fails = 0;

  logic [7:0] mRoute [8];
  logic [2:0] mCode;
  logic       mSci;

  always #2.5 clk = ~clk;

  pirq_irq_router u_pirq_irq_router (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .sciWr(sciWr), .sciVal(sciVal),
    .pirqLevel(pirqLevel), .picIrq(picIrq), .apicIrq(apicIrq),
    .qryPirq(qryPirq), .qryMode(qryMode), .qryIrq(qryIrq)
  );

  // R6: code to interrupt number, -1 for reserved
  function automatic int sciLine(input logic [2:0] c);
    case (c)
      3'd0: return 9;
      3'd1: return 10;
      3'd2: return 11;
      3'd3: return 20;
      3'd4: return 21;
      default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] expPic();
    logic [15:0] r = '0;
    int s = sciLine(mCode);
    for (int n = 0; n < 8; n++)
      if (!mRoute[n][7] && mRoute[n][4:0] < 16 && pirqLevel[n])
        r[mRoute[n][3:0]] = 1'b1;
    if (mSci && s >= 0 && s < 16) r[s] = 1'b1;
    return r;
  endfunction

  function automatic logic [23:0] expApic();
    logic [23:0] r = '0;
    int s = sciLine(mCode);
    r[23:16] = pirqLevel;
    if (mSci && s >= 0) r[s] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(tag, 32'(picIrq), 32'(expPic()), "picIrq");
    chk(tag, 32'(apicIrq), 32'(expApic()), "apicIrq");
    for (int q = 0; q < 8; q++) begin
      logic [1:0] em;
      logic [4:0] ei;
      qryPirq = 3'(q);
      #0.05;
      if (mRoute[q][7]) begin em = 2'd1; ei = 5'(16 + q); end
      else if (mRoute[q][4:0] >= 16) begin em = 2'd2; ei = 5'd0; end
      else begin em = 2'd0; ei = mRoute[q][4:0]; end
      chk(tag, 32'(qryMode), 32'(em), $sformatf("qryMode[%0d]", q));
      chk(tag, 32'(qryIrq), 32'(ei), $sformatf("qryIrq[%0d]", q));
    end
  endtask

  task automatic cfgWrite(input logic [3:0] a, input logic [7:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
    if (a < 8) mRoute[a[2:0]] = d;          // R11
    else if (a == 8) mCode = d[2:0];
  endtask

  task automatic sciPulse(input logic [3:0] v);
    sciWr = 1'b1; sciVal = v;
    @(posedge clk); #1;
    sciWr = 1'b0; sciVal = $urandom_range(15);
    mSci = |v;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int n = 0; n < 8; n++) mRoute[n] = 8'h80;
    mCode = 3'd0; mSci = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // R1: reset state
    checkAll("R1");
    pirqLevel = 8'hFF; #0.5;
    checkAll("R1");

    // R2 / R3: two lines on one pin, then one taken off
    pirqLevel = 8'h00;
    cfgWrite(4'd0, 8'h05);
    cfgWrite(4'd1, 8'h65);                 // bits 6:5 set, no effect
    pirqLevel = 8'h02; #0.5; checkAll("R3");
    pirqLevel = 8'h03; #0.5; checkAll("R3");
    cfgWrite(4'd1, 8'h85);
    pirqLevel = 8'h02; #0.5; checkAll("R2");

    // R4: pin field 20
    cfgWrite(4'd2, 8'h14);
    pirqLevel = 8'h04; #0.5; checkAll("R4");
    checkAll("R10");

    // R5: APIC independent of steering
    pirqLevel = 8'hA5; #0.5; checkAll("R5");

    // R6 R7 R8: each SCI code, level high and low
    pirqLevel = 8'h00;
    for (int c = 0; c < 8; c++) begin
      cfgWrite(4'd8, 8'(c) | 8'hF8);
      sciPulse(4'h4); checkAll("R7");
      if (c >= 3) checkAll("R8"); else checkAll("R6");
      sciPulse(4'h0); checkAll("R6");
    end

    // R9: repeated same level, strobe absent
    cfgWrite(4'd8, 8'h01);
    sciPulse(4'h8); sciPulse(4'h1); checkAll("R9");
    sciVal = 4'h0; @(posedge clk); #1; checkAll("R9");

    // R11: unused addresses
    for (int a = 9; a < 16; a++) cfgWrite(4'(a), 8'h03);
    checkAll("R11");

    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(3) != 0)
        cfgWrite(4'($urandom_range(15)), 8'($urandom));
      if ($urandom_range(3) == 0) sciPulse(4'($urandom_range(15)));
      pirqLevel = 8'($urandom);
      #0.5;
      checkAll("R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule